// File: doc/BRIEF.md
# Asynchronous Memory Request Tracker

This block lets a processor core keep a large number of non-blocking memory reads and writes in flight at once. The core presents a request on the issue port: a far-memory address, a scratchpad address, a byte length, a direction flag and a resume tag. In the same cycle the block hands back an identifier taken from its pool of free identifiers, so the issuing instruction can retire without waiting for any data.

Each accepted request is cut into pieces whose size is two to the power of the granularity input, sampled at issue. Pieces leave on the memory-side port one per cycle, and the pending requests share that port in round-robin order. Responses come back in any order, each tagged with its identifier. When the last piece of a request has been answered, its identifier joins a finished queue. Software polls that queue to get the identifier and resume tag of the oldest finished request. Only that poll puts the identifier back into the free pool.

Top module: `async_mem_tracker`

## Requirements
- R1: An accepted issue returns its identifier combinationally in the same cycle. Identifiers leave the free pool in first-in first-out order, and after reset the pool holds 0, 1, ..., NUM_IDS-1 in that order.
- R2: issueReady is low exactly when every identifier is held by a request that has not yet been polled, and no request is accepted while it is low.
- R3: A request of L bytes at granularity G (granLog2) becomes ceil(L / 2^G) pieces, and a length of 0 counts as one piece. Piece k carries far address far+k*2^G, scratchpad address spm+k*2^G, the request's direction flag (1 = write) and its identifier.
- R4: The memory-side port presents at most one piece per cycle. memReqValid stays high while a piece is pending and memReqReady is low. A piece is consumed only in a cycle where both are high.
- R5: The memory-side port chooses among identifiers with unsent pieces in round-robin order. After granting identifier k, the next grant goes to the first pending identifier above k, wrapping from NUM_IDS-1 to 0. After reset the search starts at identifier 0.
- R6: Responses may arrive in any order, one per cycle, and each carries an identifier. A request finishes in the cycle its response count reaches its piece count. Finished identifiers are queued in the order they finished.
- R7: A poll while the finished queue is not empty returns pollValid=1, the oldest finished identifier and that request's resume tag, and removes the identifier from the queue.
- R8: A poll while the finished queue is empty returns pollValid=0, pollId=0 and pollTag=0, and changes neither the free pool nor issueReady.
- R9: An identifier returns to the free pool only when it is polled, never when its request finishes. It goes in at the tail of the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| granLog2 | input | GRAN_W | Piece size as log2 bytes, sampled at issue |
| issueValid | input | 1 | Issue request present |
| issueReady | output | 1 | A free identifier is available |
| issueWrite | input | 1 | 1 = write, 0 = read |
| issueFarAddr | input | ADDR_W | Far-memory start address |
| issueSpmAddr | input | SPM_W | Scratchpad start address |
| issueLen | input | LEN_W | Length in bytes |
| issueTag | input | TAG_W | Resume tag |
| issueId | output | ID_W | Identifier given to the request |
| memReqValid | output | 1 | Piece present on memory port |
| memReqReady | input | 1 | Memory side accepts the piece |
| memReqWrite | output | 1 | Direction of the piece |
| memReqFarAddr | output | ADDR_W | Far address of the piece |
| memReqSpmAddr | output | SPM_W | Scratchpad address of the piece |
| memReqId | output | ID_W | Identifier owning the piece |
| memRspValid | input | 1 | One piece answered |
| memRspId | input | ID_W | Identifier of the answered piece |
| pollReq | input | 1 | Poll the finished queue |
| pollValid | output | 1 | Poll returned a finished request |
| pollId | output | ID_W | Polled identifier, 0 when empty |
| pollTag | output | TAG_W | Resume tag of polled request, 0 when empty |

## Verification
The assertions check on every cycle that no request is accepted with an empty pool, and that a stalled piece stays offered. They also check that a final response grows the finished queue, that a successful poll returns exactly one identifier to the pool, that an empty poll reads as zeros, and that pool plus queue never exceed the table size. Only the bench scenarios can show the values themselves. These are the identifier order out of the pool, the piece count and address stepping at several granularities, the round-robin grant order, the finish order under out-of-order responses, and the reuse of a polled identifier once the pool has run dry.

// File: rtl/amt_pkg.sv
package amt_pkg;
  typedef struct packed {
    logic allocEn;
    logic sendEn;
    logic rspEn;
    logic relEn;
  } amt_strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} amt_state_t;
endpackage

// File: rtl/amt_ctrl.sv
module amt_ctrl
  import amt_pkg::*;
#(
  parameter int NUM_IDS = 64,
  localparam int ID_W = $clog2(NUM_IDS),
  localparam int CNT_W = ID_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  output logic              issueReady,
  output logic [ID_W-1:0]   issueId,
  input  logic [NUM_IDS-1:0] pendingVec,
  input  logic              memReqReady,
  output logic              memReqValid,
  output logic [ID_W-1:0]   grantId,
  input  logic              memRspValid,
  input  logic [ID_W-1:0]   memRspId,
  input  logic              rspLast,
  input  logic              pollReq,
  output logic              pollValid,
  output logic [ID_W-1:0]   pollId,
  output amt_strobe_t       strb,
  output logic [CNT_W-1:0]  freeCount,
  output logic [CNT_W-1:0]  finCount
);
  logic [ID_W-1:0] freeMem [NUM_IDS];
  logic [ID_W-1:0] finMem  [NUM_IDS];
  logic [ID_W-1:0] freeHead, freeTail, finHead, finTail, rrPtr;
  logic doIssue, doSend, doFinish;

  function automatic logic [ID_W-1:0] nextPtr(input logic [ID_W-1:0] p);
    return (p == ID_W'(NUM_IDS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign issueReady = (freeCount != '0);
  assign issueId    = freeMem[freeHead];
  assign doIssue    = issueValid && issueReady;
  assign pollValid  = pollReq && (finCount != '0);
  assign pollId     = pollValid ? finMem[finHead] : '0;
  assign doFinish   = memRspValid && rspLast;

  // round-robin search starting just after the last grant
  always_comb begin
    memReqValid = 1'b0;
    grantId     = '0;
    for (int i = 0; i < NUM_IDS; i++) begin
      int k;
      k = (int'(rrPtr) + 1 + i) % NUM_IDS;
      if (!memReqValid && pendingVec[k]) begin
        memReqValid = 1'b1;
        grantId     = ID_W'(k);
      end
    end
  end
  assign doSend = memReqValid && memReqReady;

  assign strb.allocEn = doIssue;
  assign strb.sendEn  = doSend;
  assign strb.rspEn   = memRspValid;
  assign strb.relEn   = pollValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_IDS; i++) begin
        freeMem[i] <= ID_W'(i);
        finMem[i]  <= '0;
      end
      freeHead  <= '0;
      freeTail  <= '0;
      finHead   <= '0;
      finTail   <= '0;
      freeCount <= CNT_W'(NUM_IDS);
      finCount  <= '0;
      rrPtr     <= ID_W'(NUM_IDS - 1);
    end else begin
      if (doIssue) freeHead <= nextPtr(freeHead);
      if (pollValid) begin
        freeMem[freeTail] <= pollId;
        freeTail          <= nextPtr(freeTail);
        finHead           <= nextPtr(finHead);
      end
      if (doFinish) begin
        finMem[finTail] <= memRspId;
        finTail         <= nextPtr(finTail);
      end
      freeCount <= freeCount + CNT_W'(pollValid) - CNT_W'(doIssue);
      finCount  <= finCount + CNT_W'(doFinish) - CNT_W'(pollValid);
      if (doSend) rrPtr <= grantId;
    end
  end
endmodule

// File: rtl/amt_dpath.sv
module amt_dpath
  import amt_pkg::*;
#(
  parameter int NUM_IDS = 64,
  parameter int ADDR_W  = 32,
  parameter int SPM_W   = 16,
  parameter int LEN_W   = 16,
  parameter int TAG_W   = 32,
  parameter int GRAN_W  = 4,
  localparam int ID_W   = $clog2(NUM_IDS),
  localparam int PC_W   = LEN_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  amt_strobe_t        strb,
  input  logic [ID_W-1:0]    allocId,
  input  logic [ID_W-1:0]    sendId,
  input  logic [ID_W-1:0]    rspId,
  input  logic [ID_W-1:0]    relId,
  input  logic [GRAN_W-1:0]  granLog2,
  input  logic               inWrite,
  input  logic [ADDR_W-1:0]  inFar,
  input  logic [SPM_W-1:0]   inSpm,
  input  logic [LEN_W-1:0]   inLen,
  input  logic [TAG_W-1:0]   inTag,
  output logic [NUM_IDS-1:0] pendingVec,
  output logic               rspLast,
  output logic [ADDR_W-1:0]  reqFar,
  output logic [SPM_W-1:0]   reqSpm,
  output logic               reqWrite,
  output logic [TAG_W-1:0]   relTag
);
  logic [ADDR_W-1:0] farCur   [NUM_IDS];
  logic [SPM_W-1:0]  spmCur   [NUM_IDS];
  logic [TAG_W-1:0]  tagMem   [NUM_IDS];
  logic [GRAN_W-1:0] granMem  [NUM_IDS];
  logic              wrMem    [NUM_IDS];
  logic [PC_W-1:0]   sendLeft [NUM_IDS];
  logic [PC_W-1:0]   rspLeft  [NUM_IDS];
  amt_state_t        state    [NUM_IDS];

  logic [PC_W-1:0] roundUp, pieces;
  assign roundUp = {1'b0, inLen} + ((PC_W'(1) << granLog2) - PC_W'(1));
  assign pieces  = ((roundUp >> granLog2) == '0) ? PC_W'(1) : (roundUp >> granLog2);

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_pend
    assign pendingVec[g] = (sendLeft[g] != '0);
  end

  assign rspLast  = (state[rspId] == ST_BUSY) && (rspLeft[rspId] == PC_W'(1));
  assign reqFar   = farCur[sendId];
  assign reqSpm   = spmCur[sendId];
  assign reqWrite = wrMem[sendId];
  assign relTag   = tagMem[relId];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_IDS; i++) begin
        sendLeft[i] <= '0;
        rspLeft[i]  <= '0;
        state[i]    <= ST_IDLE;
      end
    end else begin
      if (strb.allocEn) begin
        sendLeft[allocId] <= pieces;
        rspLeft[allocId]  <= pieces;
        state[allocId]    <= ST_BUSY;
      end
      if (strb.sendEn) sendLeft[sendId] <= sendLeft[sendId] - PC_W'(1);
      if (strb.rspEn && state[rspId] == ST_BUSY) begin
        rspLeft[rspId] <= rspLeft[rspId] - PC_W'(1);
        if (rspLast) state[rspId] <= ST_DONE;
      end
      if (strb.relEn) state[relId] <= ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.allocEn) begin
      farCur[allocId]  <= inFar;
      spmCur[allocId]  <= inSpm;
      tagMem[allocId]  <= inTag;
      granMem[allocId] <= granLog2;
      wrMem[allocId]   <= inWrite;
    end
    if (strb.sendEn) begin
      farCur[sendId] <= farCur[sendId] + (ADDR_W'(1) << granMem[sendId]);
      spmCur[sendId] <= spmCur[sendId] + (SPM_W'(1) << granMem[sendId]);
    end
  end
endmodule

// File: rtl/async_mem_tracker.sv
module async_mem_tracker
  import amt_pkg::*;
#(
  parameter int NUM_IDS = 64,
  parameter int ADDR_W  = 32,
  parameter int SPM_W   = 16,
  parameter int LEN_W   = 16,
  parameter int TAG_W   = 32,
  parameter int GRAN_W  = 4,
  localparam int ID_W   = $clog2(NUM_IDS),
  localparam int CNT_W  = ID_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [GRAN_W-1:0] granLog2,
  input  logic              issueValid,
  output logic              issueReady,
  input  logic              issueWrite,
  input  logic [ADDR_W-1:0] issueFarAddr,
  input  logic [SPM_W-1:0]  issueSpmAddr,
  input  logic [LEN_W-1:0]  issueLen,
  input  logic [TAG_W-1:0]  issueTag,
  output logic [ID_W-1:0]   issueId,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqFarAddr,
  output logic [SPM_W-1:0]  memReqSpmAddr,
  output logic [ID_W-1:0]   memReqId,
  input  logic              memRspValid,
  input  logic [ID_W-1:0]   memRspId,
  input  logic              pollReq,
  output logic              pollValid,
  output logic [ID_W-1:0]   pollId,
  output logic [TAG_W-1:0]  pollTag
);
  amt_strobe_t        strb;
  logic [NUM_IDS-1:0] pendingVec;
  logic               rspLast;
  logic [CNT_W-1:0]   freeCount, finCount;
  logic [TAG_W-1:0]   relTag;

  amt_ctrl #(.NUM_IDS(NUM_IDS)) ctrl_i (
    .clk, .rstN, .issueValid, .issueReady, .issueId, .pendingVec, .memReqReady,
    .memReqValid, .grantId(memReqId), .memRspValid, .memRspId, .rspLast,
    .pollReq, .pollValid, .pollId, .strb, .freeCount, .finCount
  );

  amt_dpath #(
    .NUM_IDS(NUM_IDS), .ADDR_W(ADDR_W), .SPM_W(SPM_W), .LEN_W(LEN_W),
    .TAG_W(TAG_W), .GRAN_W(GRAN_W)
  ) dpath_i (
    .clk, .rstN, .strb, .allocId(issueId), .sendId(memReqId), .rspId(memRspId),
    .relId(pollId), .granLog2, .inWrite(issueWrite), .inFar(issueFarAddr),
    .inSpm(issueSpmAddr), .inLen(issueLen), .inTag(issueTag), .pendingVec,
    .rspLast, .reqFar(memReqFarAddr), .reqSpm(memReqSpmAddr),
    .reqWrite(memReqWrite), .relTag
  );

  assign pollTag = pollValid ? relTag : '0;
endmodule

// File: rtl/amt_checker.sv
module amt_checker #(
  parameter int NUM_IDS = 64,
  parameter int TAG_W   = 32,
  localparam int ID_W   = $clog2(NUM_IDS),
  localparam int CNT_W  = ID_W + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             issueValid,
  input logic             issueReady,
  input logic             memReqValid,
  input logic             memReqReady,
  input logic             memRspValid,
  input logic             rspLast,
  input logic             pollReq,
  input logic             pollValid,
  input logic [ID_W-1:0]  pollId,
  input logic [TAG_W-1:0] pollTag,
  input logic [CNT_W-1:0] freeCount,
  input logic [CNT_W-1:0] finCount
);
  a_r2_no_issue_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    (freeCount == '0) |-> !issueReady);

  a_r4_hold_when_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);

  a_r6_finish_pushes: assert property (@(posedge clk) disable iff (!rstN)
    (memRspValid && rspLast && !pollValid) |=> int'(finCount) == int'($past(finCount)) + 1);

  a_r9_poll_frees_one: assert property (@(posedge clk) disable iff (!rstN)
    pollValid |=> int'(freeCount) ==
      int'($past(freeCount)) + 1 - int'($past(issueValid && issueReady)));

  a_r8_empty_poll_zero: assert property (@(posedge clk) disable iff (!rstN)
    (pollReq && !pollValid) |-> (pollId == '0 && pollTag == '0));

  a_r2_pool_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(freeCount) + int'(finCount) <= NUM_IDS);
endmodule

bind async_mem_tracker amt_checker #(.NUM_IDS(NUM_IDS), .TAG_W(TAG_W)) chk_i (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memRspValid(memRspValid),
  .rspLast(rspLast), .pollReq(pollReq), .pollValid(pollValid), .pollId(pollId),
  .pollTag(pollTag), .freeCount(freeCount), .finCount(finCount)
);

// File: tb/async_mem_tracker_tb_top.sv
module async_mem_tracker_tb_top;
  localparam int N = 64;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  granLog2 = '0;
  logic        issueValid = 1'b0, issueWrite = 1'b0;
  logic [31:0] issueFarAddr = '0;
  logic [15:0] issueSpmAddr = '0, issueLen = '0;
  logic [31:0] issueTag = '0;
  logic        issueReady;
  logic [5:0]  issueId;
  logic        memReqValid, memReqWrite;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqFarAddr;
  logic [15:0] memReqSpmAddr;
  logic [5:0]  memReqId;
  logic        memRspValid = 1'b0;
  logic [5:0]  memRspId = '0;
  logic        pollReq = 1'b0;
  logic        pollValid;
  logic [5:0]  pollId;
  logic [31:0] pollTag;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  async_mem_tracker dut_i (
    .clk, .rstN, .granLog2, .issueValid, .issueReady, .issueWrite, .issueFarAddr,
    .issueSpmAddr, .issueLen, .issueTag, .issueId, .memReqValid, .memReqReady,
    .memReqWrite, .memReqFarAddr, .memReqSpmAddr, .memReqId, .memRspValid,
    .memRspId, .pollReq, .pollValid, .pollId, .pollTag
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_issue(input bit wr, input logic [31:0] far, input logic [15:0] spm,
                          input logic [15:0] len, input logic [31:0] tag, input logic [3:0] g,
                          input logic [5:0] expId);
    @(negedge clk);
    issueValid = 1'b1; issueWrite = wr; issueFarAddr = far; issueSpmAddr = spm;
    issueLen = len; issueTag = tag; granLog2 = g;
    #1;
    chk(issueReady == 1'b1, "R2 ready with free ids", 64'(issueReady), 64'd1);
    chk(issueId == expId, "R1 issued id", 64'(issueId), 64'(expId));
    @(posedge clk); #1 issueValid = 1'b0;
  endtask

  task automatic take_req(input logic [5:0] id, input logic [31:0] far,
                          input logic [15:0] spm, input bit wr, input string req);
    @(negedge clk);
    memReqReady = 1'b1;
    #1;
    chk(memReqValid == 1'b1, "R4 piece offered", 64'(memReqValid), 64'd1);
    chk(memReqId == id, req, 64'(memReqId), 64'(id));
    chk(memReqFarAddr == far, "R3 far address", 64'(memReqFarAddr), 64'(far));
    chk(memReqSpmAddr == spm, "R3 spm address", 64'(memReqSpmAddr), 64'(spm));
    chk(memReqWrite == wr, "R3 direction", 64'(memReqWrite), 64'(wr));
    @(posedge clk); #1 memReqReady = 1'b0;
  endtask

  task automatic send_rsp(input logic [5:0] id);
    @(negedge clk);
    memRspValid = 1'b1; memRspId = id;
    @(posedge clk); #1 memRspValid = 1'b0;
  endtask

  task automatic do_poll(input bit expV, input logic [5:0] expId, input logic [31:0] expTag,
                         input string req);
    @(negedge clk);
    pollReq = 1'b1;
    #1;
    chk(pollValid == expV, req, 64'(pollValid), 64'(expV));
    chk(pollId == expId, req, 64'(pollId), 64'(expId));
    chk(pollTag == expTag, req, 64'(pollTag), 64'(expTag));
    @(posedge clk); #1 pollReq = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(issueReady == 1'b1, "R2 ready after reset", 64'(issueReady), 64'd1);
    chk(memReqValid == 1'b0, "R4 idle after reset", 64'(memReqValid), 64'd0);
    do_poll(1'b0, 6'd0, 32'd0, "R8 empty poll after reset");
  endtask

  // R3: 40 bytes at 16-byte pieces -> 3 pieces; R6: no finish until the last response
  task automatic t_single();
    do_issue(1'b0, 32'h1000_0000, 16'h0100, 16'd40, 32'h0000_00A0, 4'd4, 6'd0);
    for (int k = 0; k < 3; k++)
      take_req(6'd0, 32'h1000_0000 + 32'(k * 16), 16'h0100 + 16'(k * 16), 1'b0, "R3 piece id");
    @(negedge clk); #1;
    chk(memReqValid == 1'b0, "R3 exactly three pieces", 64'(memReqValid), 64'd0);
    send_rsp(6'd0);
    send_rsp(6'd0);
    do_poll(1'b0, 6'd0, 32'd0, "R6 not finished before last response");
    send_rsp(6'd0);
    do_poll(1'b1, 6'd0, 32'h0000_00A0, "R7 poll returns id and tag");
    do_poll(1'b0, 6'd0, 32'd0, "R8 empty after pop");
  endtask

  // R5 round robin, R4 stall, R6 out-of-order finish, R7 oldest first
  task automatic t_round_robin();
    do_issue(1'b0, 32'h2000, 16'h0200, 16'd16, 32'hB001, 4'd3, 6'd1);
    do_issue(1'b1, 32'h3000, 16'h0300, 16'd16, 32'hB002, 4'd3, 6'd2);
    do_issue(1'b0, 32'h4000, 16'h0400, 16'd16, 32'hB003, 4'd3, 6'd3);
    for (int c = 0; c < 2; c++) begin
      @(negedge clk); #1;
      chk(memReqValid == 1'b1 && memReqId == 6'd1, "R4 stalled piece held",
          64'({memReqValid, memReqId}), 64'({1'b1, 6'd1}));
    end
    for (int r = 0; r < 2; r++) begin
      take_req(6'd1, 32'h2000 + 32'(r * 8), 16'h0200 + 16'(r * 8), 1'b0, "R5 grant order");
      take_req(6'd2, 32'h3000 + 32'(r * 8), 16'h0300 + 16'(r * 8), 1'b1, "R5 grant order");
      take_req(6'd3, 32'h4000 + 32'(r * 8), 16'h0400 + 16'(r * 8), 1'b0, "R5 grant order");
    end
    send_rsp(6'd3); send_rsp(6'd3);
    send_rsp(6'd1); send_rsp(6'd1);
    send_rsp(6'd2); send_rsp(6'd2);
    do_poll(1'b1, 6'd3, 32'hB003, "R6 finish order first");
    do_poll(1'b1, 6'd1, 32'hB001, "R6 finish order second");
    do_poll(1'b1, 6'd2, 32'hB002, "R7 finish order third");
  endtask

  // R2 pool exhaustion, R8 empty poll changes nothing, R9 reuse only after poll
  task automatic t_full();
    logic [5:0] expIds [N];
    for (int i = 0; i < 60; i++) expIds[i] = 6'(i + 4);
    expIds[60] = 6'd0; expIds[61] = 6'd3; expIds[62] = 6'd1; expIds[63] = 6'd2;
    for (int i = 0; i < N; i++)
      do_issue(1'b0, 32'h8000 + 32'(i), 16'(i), 16'd0, 32'hC000 + 32'(i), 4'd0, expIds[i]);
    @(negedge clk); #1;
    chk(issueReady == 1'b0, "R2 not ready when pool empty", 64'(issueReady), 64'd0);
    for (int i = 0; i < N; i++) begin
      @(negedge clk); memReqReady = 1'b1; #1;
      chk(memReqId == 6'((4 + i) % N), "R5 wrap grant", 64'(memReqId), 64'((4 + i) % N));
      @(posedge clk); #1 memReqReady = 1'b0;
    end
    @(negedge clk); #1;
    chk(memReqValid == 1'b0, "R3 zero length is one piece", 64'(memReqValid), 64'd0);
    send_rsp(6'd9);
    @(negedge clk); #1;
    chk(issueReady == 1'b0, "R9 finish does not free id", 64'(issueReady), 64'd0);
    do_poll(1'b1, 6'd9, 32'hC005, "R7 poll in full state");
    do_poll(1'b0, 6'd0, 32'd0, "R8 empty poll");
    do_issue(1'b0, 32'h9000, 16'h0, 16'd1, 32'hD000, 4'd0, 6'd9);
    @(negedge clk); #1;
    chk(issueReady == 1'b0, "R8 empty poll freed nothing", 64'(issueReady), 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    t_reset();
    t_single();
    t_round_robin();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule